// File: doc/BRIEF.md
# Set-Associative Tag Lookup with Aged Replacement

This block is the lookup and replacement core of an n-way set-associative cache. A word address is split into a set index (low bits) and a tag (the remaining high bits). On a lookup, the index selects one set and the tags of all ways in that set are compared at the same time. A match in any valid way is a hit and returns that way's data word. On a miss, the block reports the way that a fill into that set would replace.

Replacement approximates least-recently-used order with a small age counter per way. Any access to a way, whether a lookup hit or a fill, loads that way's age with its all-ones maximum. A free-running timer produces a tick every `TICK_PERIOD` cycles, and each tick lowers every age that is above zero by one. A stale way therefore decays towards zero, and zero-age ways are the preferred victims. A fill port writes a tag and data word into the set. It reuses a way that already holds the tag, and otherwise takes the replacement way. The write policy and the backing-memory protocol belong to the surrounding design. The data array is a plain register file.

Top module: `agecache_top`

## Requirements
- R1: After reset every way is invalid, so a lookup to any address misses and reports way 0 as the replacement way.
- R2: A lookup hits when a valid way in the indexed set (index = address mod `SETS`) holds the tag (address / `SETS`). One cycle after the request, `rsp_hit` is 1, `rsp_way` gives that way and `rsp_data` gives its stored word.
- R3: On a miss in a set that has invalid ways, `rsp_way` is the lowest-numbered invalid way and `rsp_data` is 0.
- R4: On a miss in a fully valid set, `rsp_way` is the lowest-numbered way among those with the smallest age. A zero-age way is therefore always chosen when one exists.
- R5: A lookup hit or a fill sets the age of the accessed way to its maximum value (all ones, 3 for a 2-bit age).
- R6: Ticks fall on the clock edges numbered P-1, 2P-1, and so on, counting from 0 at the first edge after reset (P = `TICK_PERIOD`). On a tick, every way not accessed in that cycle has its age lowered by one, saturating at zero.
- R7: When a tick and an access to the same way fall in the same cycle, the way's age becomes the maximum.
- R8: A fill writes its tag and data and sets the valid bit. It goes into the way that already holds the tag in that set, or otherwise into the replacement way chosen by the rules of R3 and R4 from the state before the fill.
- R9: `rsp_valid` follows `lk_valid` by one cycle. In a cycle with no lookup, `rsp_valid`, `rsp_hit`, `rsp_way` and `rsp_data` are all 0.
- R10: A lookup issued in the same cycle as a fill is answered from the contents before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Lookup word address |
| fill_valid | input | 1 | Fill request strobe |
| fill_addr | input | ADDR_W | Fill word address |
| fill_data | input | DATA_W | Fill data word |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Hit way, or the replacement way on a miss |
| rsp_data | output | DATA_W | Hit data, 0 on a miss |

## Verification
Each lookup response is registered, so it is due exactly one cycle after the request. Fills and age changes take effect at the same edge, and a tick acts on the edge that the timer count predicts. The bench drives inputs on the falling edge and updates its behavioural model for the coming rising edge. It compares all four response outputs on the next falling edge, so every comparison falls one full cycle after its stimulus. Age state has no port of its own. It is observed through the replacement way reported on misses after chosen runs of ticks, hits and coincident tick-and-access cycles.

// File: rtl/agecache_pkg.sv
// Package agecache_pkg: shared helpers for the aged-replacement cache.
// Assumes ages are unsigned counters that saturate at zero.
package agecache_pkg;
    // Width of a way index; at least one bit even for a single way.
    function automatic int way_bits(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction
endpackage

// File: rtl/agecache_tick.sv
// Module agecache_tick: free-running decay timer.
// Pulses tick for one cycle every PERIOD cycles; the first pulse falls on
// the PERIOD-th rising edge after reset is released. Assumes PERIOD >= 1.
module agecache_tick #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Decode the terminal count.
    assign tick = (cnt_q == LAST);

    // Count 0..PERIOD-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (PERIOD > 1) begin : g_gap
            // R6
            tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/agecache_match.sv
// Module agecache_match: parallel tag compare across the ways of one set.
// One comparator per way; reports the hit vector, a hit flag and the
// lowest matching way. Assumes a tag is held by at most one valid way.
module agecache_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 9,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] hit_vec;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_vec[w] = set_vld[w] && (set_tags[w] == key);
        end
    endgenerate

    // Encode the lowest matching way.
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
        // R2
        hit_onehot_chk: assert ($onehot0(hit_vec));
    end
endmodule

// File: rtl/agecache_victim.sv
// Module agecache_victim: replacement choice for one set.
// Picks the lowest invalid way; if all ways are valid, the lowest-numbered
// way holding the smallest age. Purely combinational.
module agecache_victim #(
    parameter int WAYS  = 4,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            set_vld,
    input  logic [WAYS-1:0][AGE_W-1:0] set_age,
    output logic [WAY_W-1:0]           victim
);
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] old_way;
    logic [AGE_W-1:0] min_age;

    // Scan for the lowest invalid way and the lowest smallest-age way.
    always_comb begin
        inv_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!set_vld[i]) inv_way = WAY_W'(i);
        end
        old_way = '0;
        min_age = set_age[0];
        for (int i = 1; i < WAYS; i++) begin
            if (set_age[i] < min_age) begin
                min_age = set_age[i];
                old_way = WAY_W'(i);
            end
        end
        victim = (&set_vld) ? old_way : inv_way;
    end

    // Guard the choice against the set contents.
    always_comb begin
        // R3
        victim_inv_chk: assert ((&set_vld) || !set_vld[victim]);
        for (int i = 0; i < WAYS; i++) begin
            // R4
            victim_age_chk: assert (!(&set_vld) || (set_age[victim] <= set_age[i]));
        end
    end
endmodule

// File: rtl/agecache_top.sv
// Module agecache_top: n-way set-associative lookup with aged replacement.
// Word addresses: index = low IDX_W bits, tag = upper bits. Lookup answers
// one cycle later from pre-edge state; fills write at the same edge. Ages
// are set to all-ones on access and decayed by a periodic tick.
// Assumes SETS is a power of two >= 2 and WAYS is 2, 4 or 8.
module agecache_top
    import agecache_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int WAYS        = 4,
    parameter int SETS        = 8,
    parameter int AGE_W       = 2,
    parameter int TICK_PERIOD = 16,
    localparam int WAY_W      = way_bits(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
    logic [WAYS-1:0][DATA_W-1:0] dat_q [SETS];
    logic [WAYS-1:0][AGE_W-1:0]  age_q [SETS];
    logic [WAYS-1:0]             vld_q [SETS];

    logic [IDX_W-1:0] lk_set, fl_set;
    logic [TAG_W-1:0] lk_tag, fl_tag;
    logic             lk_hit, fl_hit, tick;
    logic [WAY_W-1:0] lk_hway, fl_hway, lk_vict, fl_vict, fl_way;
    logic [WAYS-1:0]  acc [SETS];

    // Split both addresses into index and tag.
    assign lk_set = lk_addr[IDX_W-1:0];
    assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
    assign fl_set = fill_addr[IDX_W-1:0];
    assign fl_tag = fill_addr[ADDR_W-1:IDX_W];

    agecache_tick #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    agecache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
        .set_tags(tag_q[lk_set]), .set_vld(vld_q[lk_set]), .key(lk_tag),
        .hit(lk_hit), .hit_way(lk_hway));

    agecache_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
        .set_tags(tag_q[fl_set]), .set_vld(vld_q[fl_set]), .key(fl_tag),
        .hit(fl_hit), .hit_way(fl_hway));

    agecache_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_lk_vict (
        .set_vld(vld_q[lk_set]), .set_age(age_q[lk_set]), .victim(lk_vict));

    agecache_victim #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_fl_vict (
        .set_vld(vld_q[fl_set]), .set_age(age_q[fl_set]), .victim(fl_vict));

    // A fill reuses a way already holding its tag, else the victim.
    assign fl_way = fl_hit ? fl_hway : fl_vict;

    // Mark every way touched this cycle by a lookup hit or a fill.
    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                acc[s][w] = (lk_valid && lk_hit && lk_set == IDX_W'(s) && lk_hway == WAY_W'(w))
                         || (fill_valid && fl_set == IDX_W'(s) && fl_way == WAY_W'(w));
            end
        end
    end

    // Age, tag, data and valid storage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                age_q[s] <= '0;
                tag_q[s] <= '0;
                dat_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (acc[s][w])                   age_q[s][w] <= AGE_MAX;
                    else if (tick && age_q[s][w] != '0) age_q[s][w] <= age_q[s][w] - 1'b1;
                end
            end
            if (fill_valid) begin
                tag_q[fl_set][fl_way] <= fl_tag;
                dat_q[fl_set][fl_way] <= fill_data;
                vld_q[fl_set][fl_way] <= 1'b1;
            end
        end
    end

    // Register the lookup response from pre-edge contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_way   <= !lk_valid ? '0 : (lk_hit ? lk_hway : lk_vict);
            rsp_data  <= (lk_valid && lk_hit) ? dat_q[lk_set][lk_hway] : '0;
        end
    end

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_way == '0 && rsp_data == '0));
    // R8
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> vld_q[$past(fl_set)][$past(fl_way)]);

    genvar gs, gw;
    generate
        for (gs = 0; gs < SETS; gs++) begin : g_set_chk
            for (gw = 0; gw < WAYS; gw++) begin : g_way_chk
                // R5 R7
                acc_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    acc[gs][gw] |=> age_q[gs][gw] == AGE_MAX);
                // R6
                decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (tick && !acc[gs][gw] && age_q[gs][gw] != '0)
                    |=> age_q[gs][gw] == $past(age_q[gs][gw]) - 1'b1);
            end
        end
    endgenerate
endmodule

// File: tb/sim_agecache_top.sv
// Bench sim_agecache_top: behavioural reference model, compared every cycle.
module sim_agecache_top;
    localparam int ADDR_W = 12, DATA_W = 16, WAYS = 4, SETS = 8, AGE_W = 2, P = 16;
    localparam int AMAX = (1 << AGE_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 1'b0, fill_valid = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0, fill_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic rsp_valid, rsp_hit;
    logic [1:0] rsp_way;
    logic [DATA_W-1:0] rsp_data;

    always #4 clk = ~clk;   // 125 MHz

    agecache_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS),
                   .AGE_W(AGE_W), .TICK_PERIOD(P)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_data(rsp_data));

    int checks = 0, errors = 0, edge_k = 0;
    int m_tag [SETS][WAYS];
    int m_dat [SETS][WAYS];
    int m_age [SETS][WAYS];
    bit m_vld [SETS][WAYS];
    int e_valid, e_hit, e_way, e_data;
    string phase = "R1";

    function automatic int find(int s, int t);
        for (int w = 0; w < WAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
        return -1;
    endfunction

    function automatic int pick(int s);
        int best = 0;
        for (int w = 0; w < WAYS; w++) if (!m_vld[s][w]) return w;
        for (int w = 1; w < WAYS; w++) if (m_age[s][w] < m_age[s][best]) best = w;
        return best;
    endfunction

    task automatic cmp(string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", phase, what, got, exp);
        end
    endtask

    // One cycle: drive, predict, update model, then compare at the next falling edge.
    task automatic step(bit lv, int la, bit fv, int fa, int fd);
        int ls, lt, fs, ft, lh, fw;
        bit tk;
        lk_valid = lv; lk_addr = ADDR_W'(la);
        fill_valid = fv; fill_addr = ADDR_W'(fa); fill_data = DATA_W'(fd);
        ls = la % SETS; lt = la / SETS; fs = fa % SETS; ft = fa / SETS;
        lh = find(ls, lt);
        e_valid = lv;
        e_hit   = (lv && lh >= 0) ? 1 : 0;
        e_way   = !lv ? 0 : (lh >= 0 ? lh : pick(ls));
        e_data  = (lv && lh >= 0) ? m_dat[ls][lh] : 0;
        fw = find(fs, ft);
        if (fw < 0) fw = pick(fs);
        tk = (edge_k % P) == P - 1;
        edge_k++;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                if ((lv && lh >= 0 && s == ls && w == lh) || (fv && s == fs && w == fw))
                    m_age[s][w] = AMAX;
                else if (tk && m_age[s][w] > 0)
                    m_age[s][w]--;
            end
        if (fv) begin
            m_tag[fs][fw] = ft; m_dat[fs][fw] = fd; m_vld[fs][fw] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        cmp("rsp_valid", int'(rsp_valid), e_valid);
        cmp("rsp_hit",   int'(rsp_hit),   e_hit);
        cmp("rsp_way",   int'(rsp_way),   e_way);
        cmp("rsp_data",  int'(rsp_data),  e_data);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_dat[s][w] = 0; m_age[s][w] = 0; m_vld[s][w] = 1'b0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset, miss reports way 0
        phase = "R1";
        step(1, 8*5 + 3, 0, 0, 0);
        step(1, 8*9 + 6, 0, 0, 0);
        // R9: idle cycle gives zero response
        phase = "R9";
        step(0, 0, 0, 0, 0);
        // R8 R3: fill set 1 with tags 1..4; invalid ways taken lowest first
        phase = "R3";
        for (int t = 1; t <= 4; t++) begin
            step(1, 8*(t+10) + 1, 1, 8*t + 1, 100 + t);
        end
        phase = "R8";
        step(1, 8*3 + 1, 1, 8*3 + 1, 555);   // refill resident tag goes to the same way
        // R2: hits return stored words
        phase = "R2";
        for (int t = 1; t <= 4; t++) step(1, 8*t + 1, 0, 0, 0);
        // R10: fill and lookup of the same address in one cycle
        phase = "R10";
        step(1, 8*7 + 2, 1, 8*7 + 2, 777);
        step(1, 8*7 + 2, 0, 0, 0);
        // R6: let ages in set 1 decay across ticks, then probe the victim
        phase = "R6";
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0);
        step(1, 8*30 + 1, 0, 0, 0);
        // R5: refresh way 2 only, decay the rest, victim skips way 2
        phase = "R5";
        step(1, 8*3 + 1, 0, 0, 0);
        for (int i = 0; i < 2*P; i++) step(1, 8*31 + 1, 0, 0, 0);
        // R7: hit way 0 every cycle through several ticks
        phase = "R7";
        for (int i = 0; i < 3*P; i++) step(1, 8*1 + 1, 0, 0, 0);
        step(1, 8*32 + 1, 0, 0, 0);
        // R4: fully valid set, miss victim is lowest smallest age
        phase = "R4";
        for (int i = 0; i < 4*P; i++) step(1, 8*33 + 1, 0, 0, 0);
        step(1, 8*2 + 1, 0, 0, 0);
        for (int i = 0; i < P; i++) step(1, 8*33 + 1, 0, 0, 0);
        // R2 R8: mixed traffic with conflicting tags
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            int a, b;
            a = int'($urandom_range(0, 8*8 - 1));
            b = int'($urandom_range(0, 8*8 - 1));
            step($urandom_range(0, 3) != 0, a, $urandom_range(0, 2) == 0, b,
                 int'($urandom_range(0, 65535)));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule